// File: doc/BRIEF.md
# Acknowledge-Gated Tick Interrupt Injector

This block sits between the expiry output of a channel-0 interval timer and an interrupt controller. Every accepted expiry is recorded in a saturating backlog counter. An interrupt pulse leaves the block only when the backlog is nonzero and the controller has acknowledged the previous interrupt. Ticks that arrive while an interrupt is still unacknowledged are therefore never dropped. They are released one per acknowledge.

A reprogram strobe carries the new channel-0 mode. That mode decides whether expiries are taken once, taken every time, or ignored. The strobe also discards the backlog and re-enables issuing.

Top module: `tick_irq_injector`

## Requirements
- R1: In an armed state, a `tick_expire` pulse without `irq_ack` in the same cycle adds one to the backlog count.
- R2: An interrupt is issued only in a cycle where the backlog is nonzero, the acknowledge flag is set, and neither `irq_ack` nor `reprog` is high. Issuing clears the acknowledge flag, so a second interrupt waits for the next acknowledge.
- R3: `irq_ack` lowers the backlog by one, never below zero, and sets the acknowledge flag.
- R4: `irq` goes high for exactly one cycle. It goes high in the cycle after the issue condition of R2 holds, and then falls.
- R5: Reset and `reprog` set the backlog to zero and set the acknowledge flag. `irq` is low in the cycle after either one.
- R6: `reprog_mode` 1 or 4 arms single-shot: only the first expiry after the strobe is accepted, and later expiries are ignored until the next `reprog`.
- R7: `reprog_mode` 2 or 3 arms repeating: every expiry is accepted.
- R8: `reprog_mode` 0, 5, 6 or 7, and the state after reset, accept no expiry. An expiry then leaves `irq` low.
- R9: The backlog is 8 bits wide and holds at 255 when further expiries arrive.
- R10: An accepted expiry and `irq_ack` in the same cycle leave the backlog unchanged and set the acknowledge flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_expire | input | 1 | One-cycle timer expiry event from channel 0 |
| irq_ack | input | 1 | One-cycle acknowledge from the interrupt controller |
| reprog | input | 1 | One-cycle strobe: channel 0 was reprogrammed |
| reprog_mode | input | 3 | Channel-0 mode, sampled with `reprog` |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that `tick_expire`, `irq_ack` and `reprog` are each sampled as one-cycle events. They also assume that `reprog_mode` only matters in cycles where `reprog` is high. They do not assume that an acknowledge follows an interrupt: acknowledges that arrive with an empty backlog must be harmless. The random stimulus therefore draws expiries, acknowledges and occasional reprograms on their own, with all eight mode codes. This covers stray acknowledges, coinciding expiry and acknowledge, and reprograms in the middle of a backlog. Directed runs fill the backlog past saturation and drain it again.

// File: rtl/tick_inj_pkg.sv
`timescale 1ns/1ps
package tick_inj_pkg;

  typedef enum logic [1:0] {
    ARM_OFF    = 2'd0,
    ARM_SINGLE = 2'd1,
    ARM_REPEAT = 2'd2
  } arm_e;

  // Mode code to arming kind: 1/4 single-shot, 2/3 repeating, rest off.
  function automatic arm_e arm_of_mode(input logic [2:0] mode);
    case (mode)
      3'd1, 3'd4: arm_of_mode = ARM_SINGLE;
      3'd2, 3'd3: arm_of_mode = ARM_REPEAT;
      default:    arm_of_mode = ARM_OFF;
    endcase
  endfunction

endpackage

// File: rtl/tick_arm.sv
`timescale 1ns/1ps
module tick_arm
  import tick_inj_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reprog,
  input  logic [2:0] reprog_mode,
  input  logic       tick_expire,
  output logic       accept
);

  arm_e arm_q;

  assign accept = tick_expire && !reprog && (arm_q != ARM_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n)
      arm_q <= ARM_OFF;
    else if (reprog)
      arm_q <= arm_of_mode(reprog_mode);
    else if (accept && arm_q == ARM_SINGLE)
      arm_q <= ARM_OFF;
  end

  AST_SINGLE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q == ARM_SINGLE && tick_expire && !reprog) |=> (arm_q == ARM_OFF)); // R6
  AST_REPEAT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q == ARM_REPEAT && !reprog) |=> (arm_q == ARM_REPEAT)); // R7

endmodule

// File: rtl/tick_backlog.sv
`timescale 1ns/1ps
module tick_backlog #(
  parameter int PEND_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reprog,
  input  logic accept,
  input  logic ack,
  input  logic fire,
  output logic pend_nz,
  output logic ack_flag
);

  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
  localparam logic [PEND_W-1:0] PEND_ONE = {{(PEND_W-1){1'b0}}, 1'b1};

  logic [PEND_W-1:0] pend_q;
  logic              ack_q;
  logic              bump_up;
  logic              bump_dn;

  // Saturating step: up holds at max, down holds at zero.
  function automatic logic [PEND_W-1:0] pend_step(
    input logic [PEND_W-1:0] cur, input logic up, input logic dn);
    if (up && cur != PEND_MAX)       pend_step = cur + PEND_ONE;
    else if (dn && cur != '0)        pend_step = cur - PEND_ONE;
    else                             pend_step = cur;
  endfunction

  assign bump_up  = accept && !ack;
  assign bump_dn  = ack && !accept;
  assign pend_nz  = (pend_q != '0);
  assign ack_flag = ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n || reprog) begin
      pend_q <= '0;
      ack_q  <= 1'b1;
    end else begin
      pend_q <= pend_step(pend_q, bump_up, bump_dn);
      if (ack)       ack_q <= 1'b1;
      else if (fire) ack_q <= 1'b0;
    end
  end

  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!reprog && accept && !ack && pend_q == PEND_MAX) |=> (pend_q == PEND_MAX)); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!reprog && ack && !accept && pend_q == '0) |=> (pend_q == '0)); // R3
  AST_ACK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!reprog && ack) |=> ack_q); // R3
  AST_ISSUE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!reprog && fire && !ack) |=> !ack_q); // R2
  AST_REPROG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reprog |=> (pend_q == '0 && ack_q)); // R5
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reprog && accept && ack) |=> $stable(pend_q)); // R10
  AST_ACCEPT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reprog && accept && !ack && pend_q != PEND_MAX) |=> (pend_q != '0)); // R1

endmodule

// File: rtl/tick_issue.sv
`timescale 1ns/1ps
module tick_issue (
  input  logic clk,
  input  logic rst_n,
  input  logic reprog,
  input  logic ack,
  input  logic pend_nz,
  input  logic ack_flag,
  output logic fire,
  output logic irq
);

  logic irq_q;

  assign fire = pend_nz && ack_flag && !ack && !reprog;
  assign irq  = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire;
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R4
  AST_ISSUE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(pend_nz && ack_flag)); // R2

endmodule

// File: rtl/tick_irq_injector.sv
`timescale 1ns/1ps
module tick_irq_injector #(
  parameter int PEND_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_expire,
  input  logic       irq_ack,
  input  logic       reprog,
  input  logic [2:0] reprog_mode,
  output logic       irq
);

  logic accept;
  logic fire;
  logic pend_nz;
  logic ack_flag;

  tick_arm u_arm (
    .clk(clk), .rst_n(rst_n), .reprog(reprog), .reprog_mode(reprog_mode),
    .tick_expire(tick_expire), .accept(accept)
  );

  tick_backlog #(.PEND_W(PEND_W)) u_backlog (
    .clk(clk), .rst_n(rst_n), .reprog(reprog), .accept(accept),
    .ack(irq_ack), .fire(fire), .pend_nz(pend_nz), .ack_flag(ack_flag)
  );

  tick_issue u_issue (
    .clk(clk), .rst_n(rst_n), .reprog(reprog), .ack(irq_ack),
    .pend_nz(pend_nz), .ack_flag(ack_flag), .fire(fire), .irq(irq)
  );

  AST_QUIET_AFTER_REPROG: assert property (@(posedge clk) disable iff (!rst_n)
    reprog |=> !irq); // R5

endmodule

// File: tb/tick_irq_injector_test.sv
`timescale 1ns/1ps
module tick_irq_injector_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_expire = 1'b0;
  logic       irq_ack = 1'b0;
  logic       reprog = 1'b0;
  logic [2:0] reprog_mode = 3'd0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit finished = 0;

  // reference state: kind 0 none, 1 single, 2 repeat
  int  m_cnt = 0;
  bit  m_flag = 1;
  int  m_kind = 0;
  bit  m_irq = 0;

  always #2.5 clk = ~clk;

  tick_irq_injector uut (
    .clk(clk), .rst_n(rst_n), .tick_expire(tick_expire), .irq_ack(irq_ack),
    .reprog(reprog), .reprog_mode(reprog_mode), .irq(irq)
  );

  function automatic int kind_for(input int mode);
    if (mode == 1 || mode == 4) return 1;
    if (mode == 2 || mode == 3) return 2;
    return 0;
  endfunction

  function automatic int clamp_cnt(input int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_edge(input bit e, input bit a, input bit r, input int mode);
    bit took;
    bit issue;
    if (r) begin
      m_cnt = 0; m_flag = 1; m_kind = kind_for(mode); m_irq = 0;
    end else begin
      issue = (m_cnt > 0) && m_flag && !a;
      took  = e && (m_kind != 0);
      if (took && m_kind == 1) m_kind = 0;
      m_cnt = clamp_cnt(m_cnt + (took ? 1 : 0) - (a ? 1 : 0));
      if (a) m_flag = 1;
      else if (issue) m_flag = 0;
      m_irq = issue;
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit e, input bit a, input bit r, input int mode);
    tick_expire = e; irq_ack = a; reprog = r; reprog_mode = mode[2:0];
    @(posedge clk);
    model_edge(e, a, r, mode);
    @(negedge clk);
    if (irq) irq_seen++;
    check(irq === m_irq, "R4 irq vs reference", int'(irq), int'(m_irq));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(irq === 1'b0, "R5 irq low after reset", int'(irq), 0);

    // R8: nothing armed after reset
    irq_seen = 0;
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
    idle(5);
    check(irq_seen == 0, "R8 expiry ignored after reset", irq_seen, 0);

    // R1 R2 R3: backlog of five in repeating mode 2
    cyc(0, 0, 1, 2);
    irq_seen = 0;
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
    idle(4);
    check(irq_seen == 1, "R2 one irq until acknowledged", irq_seen, 1);
    for (int i = 0; i < 4; i++) begin cyc(0, 1, 0, 0); idle(3); end
    check(irq_seen == 5, "R1 every backlogged tick released", irq_seen, 5);
    cyc(0, 1, 0, 0); idle(3);
    cyc(0, 1, 0, 0); idle(3);
    check(irq_seen == 5, "R3 extra acks issue nothing", irq_seen, 5);
    cyc(1, 0, 0, 0); idle(3);
    check(irq_seen == 6, "R3 backlog floored at zero", irq_seen, 6);

    // R6: single-shot mode 4
    cyc(0, 0, 1, 4);
    irq_seen = 0;
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
    idle(4);
    cyc(0, 1, 0, 0); idle(4);
    cyc(1, 0, 0, 0); idle(4);
    check(irq_seen == 1, "R6 single-shot accepts one expiry", irq_seen, 1);

    // R8: mode 6 is off
    cyc(0, 0, 1, 6);
    irq_seen = 0;
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); idle(4);
    check(irq_seen == 0, "R8 mode 6 ignores expiry", irq_seen, 0);

    // R7: repeating mode 3
    cyc(0, 0, 1, 3);
    irq_seen = 0;
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); idle(3);
    cyc(0, 1, 0, 0); idle(3);
    check(irq_seen == 2, "R7 mode 3 accepts every expiry", irq_seen, 2);

    // R10: expiry with ack in the same cycle
    cyc(0, 0, 1, 2);
    irq_seen = 0;
    cyc(1, 0, 0, 0); idle(3);
    cyc(1, 1, 0, 0); idle(3);
    check(irq_seen == 2, "R10 same-cycle ack re-enables issue", irq_seen, 2);
    cyc(0, 1, 0, 0); idle(4);
    check(irq_seen == 2, "R10 backlog unchanged by coinciding events", irq_seen, 2);

    // R9: saturation
    cyc(0, 0, 1, 2);
    irq_seen = 0;
    for (int i = 0; i < 300; i++) cyc(1, 0, 0, 0);
    for (int i = 0; i < 300; i++) begin cyc(0, 1, 0, 0); idle(2); end
    check(irq_seen == 255, "R9 backlog held at 255", irq_seen, 255);

    // R5: reprogram discards backlog and sets the flag
    cyc(0, 0, 1, 2);
    irq_seen = 0;
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
    idle(3);
    cyc(0, 0, 1, 2);
    check(irq === 1'b0, "R5 irq low after reprogram", int'(irq), 0);
    idle(4);
    check(irq_seen == 1, "R5 backlog discarded", irq_seen, 1);
    cyc(1, 0, 0, 0); idle(3);
    check(irq_seen == 2, "R5 flag set by reprogram", irq_seen, 2);

    // random mix against the reference
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 64) == 0,
          int'($urandom % 8));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule